// File: doc/BRIEF.md
# Subtract, Extend and Decrement Unit

This block executes one instruction per clock for a small group of 16-bit-encoded integer operations. The operations are decrement-with-zero-test, byte and half-word sign or zero extension, negate, negate with borrow, subtract, subtract with borrow, and subtract with signed-overflow detection. The unit holds sixteen general registers and a single condition flag, called T. Each instruction names a destination and source register, Rn in bits 11:8 and Rm in bits 7:4. It reads both registers, writes the result back to Rn, and updates T where the opcode says so.

Outside the instruction path there is a load port for initialising any register and a separate input that sets T. Every accepted instruction produces a registered writeback report on the clock edge that executes it: a valid strobe, the index and the data. An encoding outside the group raises a one-cycle illegal flag instead. Depending on the opcode, T serves as a borrow input, a borrow output, an overflow flag or a zero indicator.

Top module: `sub_ext_unit`

## Requirements
- R1: After reset all sixteen registers hold zero, T is 0, and wb_valid and illegal are 0.
- R2: Encoding 0x4n10 (hex) writes Rn-1 to Rn. It sets T to 1 when the new value is zero and clears T to 0 otherwise.
- R3: With the high nibble 6, a low nibble of 0xE sign-extends bits 7:0 of Rm into Rn, and a low nibble of 0xF sign-extends bits 15:0 of Rm into Rn. T is unchanged.
- R4: With the high nibble 6, a low nibble of 0xC zero-extends bits 7:0 of Rm into Rn, and a low nibble of 0xD zero-extends bits 15:0 of Rm into Rn. T is unchanged.
- R5: With the high nibble 6 and a low nibble of 0xB, the unit writes 0-Rm to Rn and leaves T unchanged.
- R6: With the high nibble 6 and a low nibble of 0xA, the unit writes 0-Rm-T to Rn, and T takes the borrow out of bit 31.
- R7: With the high nibble 3 and a low nibble of 0x8, the unit writes Rn-Rm to Rn and leaves T unchanged.
- R8: With the high nibble 3 and a low nibble of 0xA, the unit writes Rn-Rm-T to Rn, and T takes the borrow out.
- R9: With the high nibble 3 and a low nibble of 0xB, the unit writes Rn-Rm to Rn. T is 1 exactly when the signs of Rn and Rm differ and the sign of the result differs from the sign of Rn.
- R10: An encoding outside this group, when presented with inst_valid high, raises illegal for one cycle. It writes no register and does not change T. With inst_valid low, no instruction has any effect.
- R11: Each instruction completes in one clock. wb_valid, wb_idx and wb_data report the write on the edge that executes it, and the next instruction reads the updated register.
- R12: When ld_en is high, the load port writes ld_data into register ld_idx, and t_ld_en loads t_ld_val into T. An executing legal instruction overrides the load port in the same cycle, and an instruction that writes T overrides t_ld_en. Register 0 is an ordinary register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inst_valid | input | 1 | Instruction present this cycle |
| inst | input | 16 | Instruction word |
| ld_en | input | 1 | Register load strobe |
| ld_idx | input | 4 | Register load index |
| ld_data | input | DATA_W | Register load value |
| t_ld_en | input | 1 | T load strobe |
| t_ld_val | input | 1 | T load value |
| wb_valid | output | 1 | A register was written by an instruction |
| wb_idx | output | 4 | Index of the written register |
| wb_data | output | DATA_W | Value written |
| t_flag | output | 1 | Current T flag |
| illegal | output | 1 | Previous instruction was not recognised |

## Verification
The bench builds the unit with DATA_W at 32, which is its default. That width brings the sign boundaries 0x80000000 and 0x7FFFFFFF and the full-width borrow out of bit 31 within reach of directed tests of the overflow and borrow rules. Register contents are observed through the normal interface: a negate into a scratch register reports the value. A random phase then mixes legal and illegal encodings, load-port writes and T loads against a reference model.

// File: rtl/sub_ext_unit.sv
module sub_ext_unit #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              inst_valid,
  input  logic [15:0]       inst,
  input  logic              ld_en,
  input  logic [3:0]        ld_idx,
  input  logic [DATA_W-1:0] ld_data,
  input  logic              t_ld_en,
  input  logic              t_ld_val,
  output logic              wb_valid,
  output logic [3:0]        wb_idx,
  output logic [DATA_W-1:0] wb_data,
  output logic              t_flag,
  output logic              illegal
);
  localparam int NREG = 16;

  logic [DATA_W-1:0] regs [NREG];
  logic [DATA_W-1:0] rn, rm, res;
  logic [DATA_W:0]   dif;
  logic              legal, t_wr, t_new, exec;

  wire [3:0] f_hi = inst[15:12];
  wire [3:0] f_lo = inst[3:0];
  wire [3:0] n    = inst[11:8];
  wire [3:0] m    = inst[7:4];

  wire is_dt   = inst_valid && f_hi == 4'h4 && inst[7:0] == 8'h10;
  wire is_neg  = inst_valid && f_hi == 4'h6 && f_lo == 4'hB;
  wire is_sub  = inst_valid && f_hi == 4'h3 && f_lo == 4'h8;
  wire is_subv = inst_valid && f_hi == 4'h3 && f_lo == 4'hB;

  assign rn   = regs[n];
  assign rm   = regs[m];
  assign exec = inst_valid && legal;

  always_comb begin
    legal = 1'b0;
    t_wr  = 1'b0;
    t_new = t_flag;
    dif   = '0;
    res   = '0;
    case (f_hi)
      4'h4: if (inst[7:0] == 8'h10) begin
        legal = 1'b1;
        dif   = {1'b0, rn} - {{DATA_W{1'b0}}, 1'b1};
        res   = dif[DATA_W-1:0];
        t_wr  = 1'b1;
        t_new = (res == '0);
      end
      4'h6: case (f_lo)
        4'hC: begin legal = 1'b1; res = {{(DATA_W-8){1'b0}}, rm[7:0]}; end
        4'hD: begin legal = 1'b1; res = {{(DATA_W-16){1'b0}}, rm[15:0]}; end
        4'hE: begin legal = 1'b1; res = {{(DATA_W-8){rm[7]}}, rm[7:0]}; end
        4'hF: begin legal = 1'b1; res = {{(DATA_W-16){rm[15]}}, rm[15:0]}; end
        4'hB: begin
          legal = 1'b1;
          dif   = {(DATA_W+1){1'b0}} - {1'b0, rm};
          res   = dif[DATA_W-1:0];
        end
        4'hA: begin
          legal = 1'b1;
          dif   = {(DATA_W+1){1'b0}} - {1'b0, rm} - {{DATA_W{1'b0}}, t_flag};
          res   = dif[DATA_W-1:0];
          t_wr  = 1'b1;
          t_new = dif[DATA_W];
        end
        default: ;
      endcase
      4'h3: case (f_lo)
        4'h8: begin
          legal = 1'b1;
          dif   = {1'b0, rn} - {1'b0, rm};
          res   = dif[DATA_W-1:0];
        end
        4'hA: begin
          legal = 1'b1;
          dif   = {1'b0, rn} - {1'b0, rm} - {{DATA_W{1'b0}}, t_flag};
          res   = dif[DATA_W-1:0];
          t_wr  = 1'b1;
          t_new = dif[DATA_W];
        end
        4'hB: begin
          legal = 1'b1;
          dif   = {1'b0, rn} - {1'b0, rm};
          res   = dif[DATA_W-1:0];
          t_wr  = 1'b1;
          t_new = (rn[DATA_W-1] != rm[DATA_W-1]) && (res[DATA_W-1] != rn[DATA_W-1]);
        end
        default: ;
      endcase
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
      t_flag   <= 1'b0;
      wb_valid <= 1'b0;
      wb_idx   <= '0;
      wb_data  <= '0;
      illegal  <= 1'b0;
    end else begin
      wb_valid <= exec;
      illegal  <= inst_valid && !legal;
      if (exec) begin
        regs[n] <= res;
        wb_idx  <= n;
        wb_data <= res;
      end else if (ld_en) begin
        regs[ld_idx] <= ld_data;
      end
      if (exec && t_wr) t_flag <= t_new;
      else if (t_ld_en) t_flag <= t_ld_val;
    end
  end

  // R11
  wb_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_valid |-> wb_idx == $past(inst[11:8]));

  // R2
  dt_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_dt) && wb_valid |-> t_flag == (wb_data == '0));

  // R5
  neg_keep_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past((is_neg || is_sub) && !t_ld_en) |-> $stable(t_flag));

  // R9
  subv_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(is_subv) |-> t_flag == ($past(rn[DATA_W-1] != rm[DATA_W-1]) &&
                                  (wb_data[DATA_W-1] != $past(rn[DATA_W-1]))));

  // R10
  illegal_t_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal && $past(!t_ld_en) |-> $stable(t_flag) && !wb_valid);
endmodule

// File: tb/sub_ext_unit_bench.sv
module sub_ext_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        inst_valid = 1'b0;
  logic [15:0] inst = '0;
  logic        ld_en = 1'b0;
  logic [3:0]  ld_idx = '0;
  logic [31:0] ld_data = '0;
  logic        t_ld_en = 1'b0;
  logic        t_ld_val = 1'b0;
  logic        wb_valid;
  logic [3:0]  wb_idx;
  logic [31:0] wb_data;
  logic        t_flag;
  logic        illegal;

  sub_ext_unit #(.DATA_W(32)) u_sub_ext_unit (
    .clk(clk), .rst_n(rst_n), .inst_valid(inst_valid), .inst(inst),
    .ld_en(ld_en), .ld_idx(ld_idx), .ld_data(ld_data),
    .t_ld_en(t_ld_en), .t_ld_val(t_ld_val),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .wb_data(wb_data),
    .t_flag(t_flag), .illegal(illegal)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic        wv;
    logic [3:0]  idx;
    logic [31:0] data;
    logic        t;
    logic        ill;
  } exp_t;

  exp_t        q_exp[$];
  string       q_tag[$];
  logic [31:0] mr [16];
  logic        mt = 1'b0;
  int          total = 0;
  int          bad = 0;
  bit          done = 1'b0;

  task automatic step(input bit iv, input logic [15:0] ins,
                      input bit le, input logic [3:0] li, input logic [31:0] ld,
                      input bit tle, input bit tlv, input string tag);
    logic [3:0]  n, m;
    logic [31:0] a, b, r;
    logic [32:0] d;
    bit          leg, tw, tn;
    exp_t        e;
    n = ins[11:8]; m = ins[7:4]; a = mr[n]; b = mr[m];
    leg = 0; tw = 0; tn = mt; r = '0; d = '0;
    if (ins[15:12] == 4'h4 && ins[7:0] == 8'h10) begin
      leg = 1; r = a - 32'd1; tw = 1; tn = (r == 0);
    end else if (ins[15:12] == 4'h6) begin
      case (ins[3:0])
        4'hC: begin leg = 1; r = {24'h0, b[7:0]}; end
        4'hD: begin leg = 1; r = {16'h0, b[15:0]}; end
        4'hE: begin leg = 1; r = {{24{b[7]}}, b[7:0]}; end
        4'hF: begin leg = 1; r = {{16{b[15]}}, b[15:0]}; end
        4'hB: begin leg = 1; r = 32'd0 - b; end
        4'hA: begin leg = 1; d = 33'd0 - {1'b0, b} - {32'd0, mt}; r = d[31:0]; tw = 1; tn = d[32]; end
        default: ;
      endcase
    end else if (ins[15:12] == 4'h3) begin
      case (ins[3:0])
        4'h8: begin leg = 1; r = a - b; end
        4'hA: begin leg = 1; d = {1'b0, a} - {1'b0, b} - {32'd0, mt}; r = d[31:0]; tw = 1; tn = d[32]; end
        4'hB: begin leg = 1; r = a - b; tw = 1; tn = (a[31] != b[31]) && (r[31] != a[31]); end
        default: ;
      endcase
    end
    e.wv = iv && leg; e.idx = n; e.data = r; e.ill = iv && !leg;
    if (iv && leg) mr[n] = r;
    else if (le) mr[li] = ld;
    if (iv && leg && tw) mt = tn;
    else if (tle) mt = tlv;
    e.t = mt;
    @(negedge clk);
    inst_valid = iv; inst = ins; ld_en = le; ld_idx = li; ld_data = ld;
    t_ld_en = tle; t_ld_val = tlv;
    @(posedge clk);
    #1;
    q_exp.push_back(e);
    q_tag.push_back(tag);
  endtask

  task automatic exec_i(input logic [15:0] ins, input string tag);
    step(1'b1, ins, 1'b0, 4'd0, 32'd0, 1'b0, 1'b0, tag);
  endtask

  task automatic load(input logic [3:0] idx, input logic [31:0] val);
    step(1'b0, 16'h0, 1'b1, idx, val, 1'b0, 1'b0, "R12 load");
  endtask

  task automatic set_t(input bit v);
    step(1'b0, 16'h0, 1'b0, 4'd0, 32'd0, 1'b1, v, "R12 tload");
  endtask

  function automatic logic [15:0] enc(input logic [3:0] hi, input logic [3:0] n,
                                      input logic [3:0] m, input logic [3:0] lo);
    return {hi, n, m, lo};
  endfunction

  initial begin : monitor
    exp_t  e;
    string tg;
    forever begin
      @(negedge clk);
      if (q_exp.size() > 0) begin
        e  = q_exp.pop_front();
        tg = q_tag.pop_front();
        total++;
        if (wb_valid !== e.wv || (e.wv && (wb_idx !== e.idx || wb_data !== e.data)) ||
            t_flag !== e.t || illegal !== e.ill) begin
          bad++;
          $display("FAIL %s: got wv=%0b idx=%0d data=%h t=%0b ill=%0b exp wv=%0b idx=%0d data=%h t=%0b ill=%0b",
                   tg, wb_valid, wb_idx, wb_data, t_flag, illegal, e.wv, e.idx, e.data, e.t, e.ill);
        end
      end
    end
  end

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : driver
    for (int i = 0; i < 16; i++) mr[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    total++;
    if (wb_valid !== 1'b0 || t_flag !== 1'b0 || illegal !== 1'b0) begin
      bad++;
      $display("FAIL R1 reset: got wv=%0b t=%0b ill=%0b exp 0 0 0", wb_valid, t_flag, illegal);
    end
    rst_n = 1'b1;
    // R1: registers read back as zero via negate into scratch
    exec_i(enc(4'h6, 4'd15, 4'd7, 4'hB), "R1 reg zero");
    exec_i(enc(4'h6, 4'd14, 4'd3, 4'hB), "R1 reg zero");
    // R7 with T preset to 1
    load(4'd2, 32'd5); load(4'd3, 32'd3); set_t(1'b1);
    exec_i(enc(4'h3, 4'd2, 4'd3, 4'h8), "R7 sub");
    // R8 with borrow in and borrow out
    exec_i(enc(4'h3, 4'd2, 4'd3, 4'hA), "R8 subc borrow");
    load(4'd4, 32'd10); set_t(1'b0);
    exec_i(enc(4'h3, 4'd4, 4'd3, 4'hA), "R8 subc no borrow");
    // R9
    load(4'd4, 32'h8000_0000); load(4'd5, 32'd1);
    exec_i(enc(4'h3, 4'd4, 4'd5, 4'hB), "R9 subv underflow");
    load(4'd4, 32'h7FFF_FFFF); load(4'd5, 32'hFFFF_FFFF);
    exec_i(enc(4'h3, 4'd4, 4'd5, 4'hB), "R9 subv overflow");
    load(4'd4, 32'd20); load(4'd5, 32'd7);
    exec_i(enc(4'h3, 4'd4, 4'd5, 4'hB), "R9 subv none");
    // R5 / R6
    set_t(1'b1);
    load(4'd6, 32'd9);
    exec_i(enc(4'h6, 4'd8, 4'd6, 4'hB), "R5 neg keeps T");
    load(4'd6, 32'd0); set_t(1'b0);
    exec_i(enc(4'h6, 4'd8, 4'd6, 4'hA), "R6 negc zero");
    set_t(1'b1);
    exec_i(enc(4'h6, 4'd8, 4'd6, 4'hA), "R6 negc T in");
    load(4'd6, 32'd5); set_t(1'b0);
    exec_i(enc(4'h6, 4'd8, 4'd6, 4'hA), "R6 negc borrow");
    // R2 and register 0 ordinary
    load(4'd0, 32'd1);
    exec_i(16'h4010, "R2 dt to zero R12 r0");
    exec_i(16'h4010, "R2 dt wrap");
    load(4'd9, 32'd3);
    exec_i(16'h4910, "R2 dt nonzero");
    exec_i(16'h4910, "R11 back to back");
    // R3 / R4
    load(4'd1, 32'h1234_5680);
    exec_i(enc(4'h6, 4'd10, 4'd1, 4'hE), "R3 exts byte neg");
    load(4'd1, 32'hFFFF_FF7F);
    exec_i(enc(4'h6, 4'd10, 4'd1, 4'hE), "R3 exts byte pos");
    load(4'd1, 32'h0001_8000);
    exec_i(enc(4'h6, 4'd10, 4'd1, 4'hF), "R3 exts word");
    load(4'd1, 32'hFFFF_FF80);
    exec_i(enc(4'h6, 4'd10, 4'd1, 4'hC), "R4 extu byte");
    exec_i(enc(4'h6, 4'd10, 4'd1, 4'hD), "R4 extu word");
    // R10
    set_t(1'b1);
    exec_i(16'h0000, "R10 illegal zero");
    exec_i(16'h4020, "R10 illegal dt form");
    exec_i(enc(4'h3, 4'd1, 4'd2, 4'h9), "R10 illegal sub form");
    exec_i(enc(4'h6, 4'd1, 4'd2, 4'h9), "R10 illegal ext form");
    exec_i(enc(4'h6, 4'd15, 4'd1, 4'hB), "R10 reg untouched");
    step(1'b0, enc(4'h6, 4'd1, 4'd2, 4'hB), 1'b0, 4'd0, 32'd0, 1'b0, 1'b0, "R10 no valid");
    exec_i(enc(4'h6, 4'd15, 4'd1, 4'hB), "R10 readback");
    // R12 precedence
    step(1'b1, enc(4'h3, 4'd2, 4'd3, 4'hA), 1'b1, 4'd7, 32'hDEAD_BEEF, 1'b1, 1'b0, "R12 inst wins");
    exec_i(enc(4'h6, 4'd15, 4'd7, 4'hB), "R12 load dropped");
    step(1'b1, enc(4'h3, 4'd2, 4'd3, 4'h8), 1'b0, 4'd0, 32'd0, 1'b1, 1'b0, "R12 tload with sub");
    // random mix
    for (int k = 0; k < 400; k++) begin
      logic [15:0] ins;
      logic [3:0]  los [9];
      los = '{4'hC, 4'hD, 4'hE, 4'hF, 4'hB, 4'hA, 4'h8, 4'hA, 4'hB};
      case ($urandom_range(0, 5))
        0: ins = {4'h4, 4'($urandom), 8'h10};
        1, 2: ins = {4'h6, 8'($urandom), los[$urandom_range(0, 5)]};
        3: ins = {4'h3, 8'($urandom), los[$urandom_range(6, 8)]};
        4: ins = 16'($urandom);
        default: ins = {4'h3, 8'($urandom), 4'h8};
      endcase
      step(1'($urandom), ins, 1'($urandom), 4'($urandom), $urandom,
           1'($urandom), 1'($urandom), "R11 random");
    end
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule